// File: doc/BRIEF.md
# Privileged Mode Boundary Guard

This block keeps, for each of a parameterised number of cores, a single bit that says whether the core runs in privileged mode or in normal mode. Every decoded instruction is shown to it as a class code, a target address and a valid strobe. The guard then decides whether the instruction crosses the mode boundary legally, is harmless, or violates the boundary. The decoder, IPR storage, TLB and caches stay outside the block. It only classifies and gates.

The only way into privileged mode is the call-privileged instruction. The only way out is the privileged-return instruction. A privileged operation issued from normal mode raises a fault that cannot be masked. The fault carries a cause code and is delivered by entering privileged mode at a fault vector.

Every boundary crossing does two things. It requests a pipeline flush with a restart address, and it pulses a clear of the load-locked/store-conditional reservation. Each core's lane is independent of every other lane.

Top module: `priv_boundary_guard`

## Requirements
- R1: Each core has exactly two states, privileged (`priv_mode`=1) and normal (`priv_mode`=0). Reset (synchronous, `rst_n` low) puts every core in privileged mode. It also clears `fault_pulse`, `fault_cause`, `flush_req`, `resv_clear` and `flush_pc`.
- R2: A valid call-privileged instruction (class 3) in normal mode takes the core to privileged mode on the next clock edge. On that edge `flush_req` and `resv_clear` pulse for one cycle, and `flush_pc` becomes `CALL_BASE`.
- R3: A valid privileged-return instruction (class 4) in privileged mode takes the core to normal mode. `flush_req` and `resv_clear` pulse, and `flush_pc` becomes the instruction's target address. No other instruction leaves privileged mode.
- R4: In normal mode, classes 4 (privileged return), 5 (move from IPR), 6 (move to IPR), 7 (privileged load) and 8 (privileged store) fault with cause 1 (illegal opcode).
- R5: In normal mode, classes 9 (cache control) and 10 (TLB control) fault with cause 2 (illegal IPR access). So does a class 2 ordinary load/store whose target's top 4 bits equal `IPR_TAG` (default 4'hE). A class 2 access elsewhere does not fault.
- R6: In normal mode, a class 1 branch whose target's top 4 bits equal `PAL_TAG` (default 4'hF) faults with cause 3 (illegal privileged-region jump). A branch elsewhere does not fault.
- R7: When one instruction meets several fault conditions, the cause is chosen by priority: 1 before 2 before 3. A privileged load into the IPR region or a privileged return into the privileged region reports cause 1. A class 4, 7 or 8 instruction is also checked against the region rules.
- R8: A fault pulses `fault_pulse` for one cycle with the cause on `fault_cause`, and the cause is 0 in every other cycle. The core enters privileged mode, with `flush_req` and `resv_clear` pulsing and `flush_pc` = `FAULT_BASE` + cause × `VEC_STRIDE`. A faulting instruction's own mode change never happens.
- R9: In privileged mode no class faults. A call-privileged instruction in privileged mode has no effect. Classes 0 and 11 to 15 never fault or change the mode.
- R10: With the valid strobe low, a lane ignores its class and address. The mode, `flush_pc` and every pulse output stay unchanged or idle.
- R11: Lanes are independent. A fault or transition on one core leaves every other core's outputs as that core's own inputs determine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | NUM_CORES | Per-core decoded instruction strobe |
| instr_class | input | NUM_CORES*4 | Per-core instruction class code (core c at bits [4c+3:4c]) |
| instr_target | input | NUM_CORES*ADDR_W | Per-core target address |
| priv_mode | output | NUM_CORES | 1 = privileged, 0 = normal |
| fault_pulse | output | NUM_CORES | One-cycle fault strobe |
| fault_cause | output | NUM_CORES*2 | Fault cause: 1 opcode, 2 IPR access, 3 region jump, 0 none |
| flush_req | output | NUM_CORES | One-cycle pipeline flush request |
| flush_pc | output | NUM_CORES*ADDR_W | Restart address for the last flush |
| resv_clear | output | NUM_CORES | One-cycle LL/SC reservation clear |

## Verification
The assertions assume that the class and target inputs are stable and known whenever the valid strobe is high at a clock edge. They also assume that reset is applied before the first valid instruction. The bench meets this by changing inputs only on the falling edge and by holding reset for the first cycles. Stimulus then mixes directed boundary sequences with per-core random classes and addresses. The random target addresses are drawn so that the privileged region, the IPR region and ordinary memory are all hit often.

// File: rtl/pbg_pkg.sv
// Shared definitions for the privileged boundary guard.
// Assumes a 4-bit instruction class and a 2-bit fault cause.
package pbg_pkg;
    localparam int CLASS_W = 4;
    localparam int CAUSE_W = 2;

    typedef enum logic [CLASS_W-1:0] {
        CL_PLAIN    = 4'd0,
        CL_BRANCH   = 4'd1,
        CL_LDST     = 4'd2,
        CL_CALLPRIV = 4'd3,
        CL_PRIVRET  = 4'd4,
        CL_MFIPR    = 4'd5,
        CL_MTIPR    = 4'd6,
        CL_PRIVLD   = 4'd7,
        CL_PRIVST   = 4'd8,
        CL_CACHECTL = 4'd9,
        CL_TLBCTL   = 4'd10
    } iclass_e;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_OPCODE = 2'd1,
        CAUSE_IPR    = 2'd2,
        CAUSE_REGION = 2'd3
    } cause_e;
endpackage

// File: rtl/pbg_classify.sv
// Combinational classifier. It decides, as if the core were in normal mode,
// which boundary violation one instruction would raise, and whether the
// instruction is a boundary entry or exit. Assumes the class is one of the
// package codes; unknown codes are treated as plain.
module pbg_classify
    import pbg_pkg::*;
#(
    parameter int          ADDR_W  = 32,
    parameter int          TAG_W   = 4,
    parameter logic [3:0]  PAL_TAG = 4'hF,
    parameter logic [3:0]  IPR_TAG = 4'hE
) (
    input  logic [CLASS_W-1:0] cls,
    input  logic [ADDR_W-1:0]  target,
    output logic               is_call,
    output logic               is_ret,
    output logic [CAUSE_W-1:0] viol_cause
);
    localparam int TAG_LSB = ADDR_W - TAG_W;

    logic [TAG_W-1:0] tag;
    logic in_pal, in_ipr;
    logic opc_bad, ipr_bad, reg_bad;

    // Region decode of the target's top bits.
    always_comb begin
        tag    = target[ADDR_W-1:TAG_LSB];
        in_pal = (tag == PAL_TAG[TAG_W-1:0]);
        in_ipr = (tag == IPR_TAG[TAG_W-1:0]);
    end

    // Independent violation conditions, one per cause.
    always_comb begin
        is_call = (cls == CL_CALLPRIV);
        is_ret  = (cls == CL_PRIVRET);
        opc_bad = (cls == CL_PRIVRET) || (cls == CL_MFIPR) || (cls == CL_MTIPR)
               || (cls == CL_PRIVLD)  || (cls == CL_PRIVST);
        ipr_bad = (cls == CL_CACHECTL) || (cls == CL_TLBCTL)
               || (in_ipr && ((cls == CL_LDST) || (cls == CL_PRIVLD) || (cls == CL_PRIVST)));
        reg_bad = in_pal && ((cls == CL_BRANCH) || (cls == CL_PRIVRET));
    end

    // Fixed priority: opcode, then IPR access, then region jump.
    always_comb begin
        if (opc_bad)      viol_cause = CAUSE_OPCODE;
        else if (ipr_bad) viol_cause = CAUSE_IPR;
        else if (reg_bad) viol_cause = CAUSE_REGION;
        else              viol_cause = CAUSE_NONE;
    end
endmodule

// File: rtl/pbg_core_lane.sv
// Mode register and boundary response for one core. Takes the classifier's
// verdict and registers mode, fault, flush and reservation-clear outputs one
// clock after a valid instruction. Assumes inputs are stable around the edge.
module pbg_core_lane
    import pbg_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] CALL_BASE  = 32'hF000_0000,
    parameter logic [ADDR_W-1:0] FAULT_BASE = 32'hF000_1000,
    parameter logic [ADDR_W-1:0] VEC_STRIDE = 32'h0000_0040
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid,
    input  logic [CLASS_W-1:0] cls,
    input  logic [ADDR_W-1:0]  target,
    input  logic               is_call,
    input  logic               is_ret,
    input  logic [CAUSE_W-1:0] viol_cause,
    output logic               priv_q,
    output logic               fault_q,
    output logic [CAUSE_W-1:0] cause_q,
    output logic               flush_q,
    output logic [ADDR_W-1:0]  flush_pc_q,
    output logic               clr_q
);
    logic [ADDR_W-1:0] fault_vec;

    // Fault vector address for the current cause.
    always_comb begin
        fault_vec = FAULT_BASE + ({{(ADDR_W-CAUSE_W){1'b0}}, viol_cause} * VEC_STRIDE);
    end

    // Mode state and one-cycle boundary pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv_q     <= 1'b1;
            fault_q    <= 1'b0;
            cause_q    <= CAUSE_NONE;
            flush_q    <= 1'b0;
            flush_pc_q <= '0;
            clr_q      <= 1'b0;
        end else begin
            fault_q <= 1'b0;
            cause_q <= CAUSE_NONE;
            flush_q <= 1'b0;
            clr_q   <= 1'b0;
            if (valid) begin
                if (!priv_q) begin
                    if (viol_cause != CAUSE_NONE) begin
                        fault_q    <= 1'b1;
                        cause_q    <= viol_cause;
                        priv_q     <= 1'b1;
                        flush_q    <= 1'b1;
                        flush_pc_q <= fault_vec;
                        clr_q      <= 1'b1;
                    end else if (is_call) begin
                        priv_q     <= 1'b1;
                        flush_q    <= 1'b1;
                        flush_pc_q <= CALL_BASE;
                        clr_q      <= 1'b1;
                    end
                end else if (is_ret) begin
                    priv_q     <= 1'b0;
                    flush_q    <= 1'b1;
                    flush_pc_q <= target;
                    clr_q      <= 1'b1;
                end
            end
        end
    end

    // R3
    exit_only_by_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(priv_q) |-> $past(valid && (cls == CL_PRIVRET)));
    // R2
    entry_by_call_or_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(priv_q) |-> (fault_q || $past(valid && (cls == CL_CALLPRIV))));
    // R8
    fault_from_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_q |-> (priv_q && !$past(priv_q) && (cause_q != CAUSE_NONE)));
    // R8
    no_cause_without_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_q |-> (cause_q == CAUSE_NONE));
    // R2
    crossing_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_q != $past(priv_q)) |-> (clr_q && flush_q));
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> (!flush_q && !clr_q && !fault_q && $stable(priv_q) && $stable(flush_pc_q)));
endmodule

// File: rtl/priv_boundary_guard.sv
// Top level: one classifier and one mode lane per core, generated from
// NUM_CORES. Lanes share nothing, so a violation on one core cannot reach
// another. Assumes packed per-core input slices, core 0 in the low bits.
module priv_boundary_guard
    import pbg_pkg::*;
#(
    parameter int                NUM_CORES  = 2,
    parameter int                ADDR_W     = 32,
    parameter int                TAG_W      = 4,
    parameter logic [3:0]        PAL_TAG    = 4'hF,
    parameter logic [3:0]        IPR_TAG    = 4'hE,
    parameter logic [ADDR_W-1:0] CALL_BASE  = 32'hF000_0000,
    parameter logic [ADDR_W-1:0] FAULT_BASE = 32'hF000_1000,
    parameter logic [ADDR_W-1:0] VEC_STRIDE = 32'h0000_0040
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_CORES-1:0]           instr_valid,
    input  logic [NUM_CORES*CLASS_W-1:0]   instr_class,
    input  logic [NUM_CORES*ADDR_W-1:0]    instr_target,
    output logic [NUM_CORES-1:0]           priv_mode,
    output logic [NUM_CORES-1:0]           fault_pulse,
    output logic [NUM_CORES*CAUSE_W-1:0]   fault_cause,
    output logic [NUM_CORES-1:0]           flush_req,
    output logic [NUM_CORES*ADDR_W-1:0]    flush_pc,
    output logic [NUM_CORES-1:0]           resv_clear
);
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic               is_call, is_ret;
        logic [CAUSE_W-1:0] viol;

        pbg_classify #(
            .ADDR_W(ADDR_W), .TAG_W(TAG_W), .PAL_TAG(PAL_TAG), .IPR_TAG(IPR_TAG)
        ) u_cls (
            .cls        (instr_class[c*CLASS_W +: CLASS_W]),
            .target     (instr_target[c*ADDR_W +: ADDR_W]),
            .is_call    (is_call),
            .is_ret     (is_ret),
            .viol_cause (viol)
        );

        pbg_core_lane #(
            .ADDR_W(ADDR_W), .CALL_BASE(CALL_BASE),
            .FAULT_BASE(FAULT_BASE), .VEC_STRIDE(VEC_STRIDE)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .valid      (instr_valid[c]),
            .cls        (instr_class[c*CLASS_W +: CLASS_W]),
            .target     (instr_target[c*ADDR_W +: ADDR_W]),
            .is_call    (is_call),
            .is_ret     (is_ret),
            .viol_cause (viol),
            .priv_q     (priv_mode[c]),
            .fault_q    (fault_pulse[c]),
            .cause_q    (fault_cause[c*CAUSE_W +: CAUSE_W]),
            .flush_q    (flush_req[c]),
            .flush_pc_q (flush_pc[c*ADDR_W +: ADDR_W]),
            .clr_q      (resv_clear[c])
        );
    end
endmodule

// File: tb/tb_priv_boundary_guard.sv
module tb_priv_boundary_guard;
    localparam int N  = 2;
    localparam int AW = 32;
    localparam logic [AW-1:0] CALLB  = 32'hF000_0000;
    localparam logic [AW-1:0] FAULTB = 32'hF000_1000;
    localparam logic [AW-1:0] STRIDE = 32'h40;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n;
    logic [N-1:0]      iv;
    logic [N*4-1:0]    ic;
    logic [N*AW-1:0]   ia;
    logic [N-1:0]      o_priv, o_fault, o_flush, o_clr;
    logic [N*2-1:0]    o_cause;
    logic [N*AW-1:0]   o_pc;

    priv_boundary_guard dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(iv), .instr_class(ic),
        .instr_target(ia), .priv_mode(o_priv), .fault_pulse(o_fault),
        .fault_cause(o_cause), .flush_req(o_flush), .flush_pc(o_pc),
        .resv_clear(o_clr)
    );

    logic          m_priv [N];
    logic          m_fault[N];
    logic [1:0]    m_cause[N];
    logic          m_flush[N];
    logic          m_clr  [N];
    logic [AW-1:0] m_pc   [N];
    int total = 0;
    int bad   = 0;
    string last_tag = "R1";
    logic rst_req;

    function automatic logic [1:0] ref_cause(logic [3:0] c, logic [AW-1:0] a);
        logic [3:0] t = a[AW-1:AW-4];
        if (c inside {4'd4, 4'd5, 4'd6, 4'd7, 4'd8}) return 2'd1;
        if (c == 4'd9 || c == 4'd10) return 2'd2;
        if (c == 4'd2 && t == 4'hE) return 2'd2;
        if (c == 4'd1 && t == 4'hF) return 2'd3;
        return 2'd0;
    endfunction

    task automatic model_tick();
        for (int c = 0; c < N; c++) begin
            if (!rst_n) begin
                m_priv[c] = 1'b1; m_fault[c] = 1'b0; m_cause[c] = 2'd0;
                m_flush[c] = 1'b0; m_clr[c] = 1'b0; m_pc[c] = '0;
            end else begin
                logic [3:0]    cl = ic[c*4 +: 4];
                logic [AW-1:0] ad = ia[c*AW +: AW];
                logic [1:0]    cz = ref_cause(cl, ad);
                m_fault[c] = 1'b0; m_cause[c] = 2'd0; m_flush[c] = 1'b0; m_clr[c] = 1'b0;
                if (iv[c]) begin
                    if (!m_priv[c]) begin
                        if (cz != 2'd0) begin
                            m_fault[c] = 1'b1; m_cause[c] = cz; m_priv[c] = 1'b1;
                            m_flush[c] = 1'b1; m_clr[c] = 1'b1;
                            m_pc[c] = FAULTB + AW'(cz) * STRIDE;
                        end else if (cl == 4'd3) begin
                            m_priv[c] = 1'b1; m_flush[c] = 1'b1; m_clr[c] = 1'b1; m_pc[c] = CALLB;
                        end
                    end else if (cl == 4'd4) begin
                        m_priv[c] = 1'b0; m_flush[c] = 1'b1; m_clr[c] = 1'b1; m_pc[c] = ad;
                    end
                end
            end
        end
    endtask

    task automatic chk(string what, int c, logic [AW-1:0] act, logic [AW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s core%0d %s actual=%0h expected=%0h", last_tag, c, what, act, exp);
        end
    endtask

    task automatic check_all();
        for (int c = 0; c < N; c++) begin
            chk("priv_mode",   c, AW'(o_priv[c]),          AW'(m_priv[c]));
            chk("fault_pulse", c, AW'(o_fault[c]),         AW'(m_fault[c]));
            chk("fault_cause", c, AW'(o_cause[c*2 +: 2]),  AW'(m_cause[c]));
            chk("flush_req",   c, AW'(o_flush[c]),         AW'(m_flush[c]));
            chk("resv_clear",  c, AW'(o_clr[c]),           AW'(m_clr[c]));
            chk("flush_pc",    c, o_pc[c*AW +: AW],        m_pc[c]);
        end
    endtask

    task automatic step(string tag, logic [N-1:0] v, logic [N*4-1:0] c, logic [N*AW-1:0] a);
        @(negedge clk);
        check_all();
        rst_n = rst_req; iv = v; ic = c; ia = a; last_tag = tag;
        @(posedge clk);
        model_tick();
    endtask

    task automatic one0(string tag, logic [3:0] c, logic [AW-1:0] a);
        step(tag, 2'b01, {4'd0, c}, {32'd0, a});
    endtask

    initial begin
        for (int c = 0; c < N; c++) begin
            m_priv[c] = 1'b1; m_fault[c] = 1'b0; m_cause[c] = 2'd0;
            m_flush[c] = 1'b0; m_clr[c] = 1'b0; m_pc[c] = '0;
        end
        rst_n = 1'b0; rst_req = 1'b0; iv = '0; ic = '0; ia = '0;
        @(posedge clk); @(posedge clk);
        step("R1", 2'b11, {4'd4, 4'd4}, '0);
        step("R1", '0, '0, '0);
        rst_req = 1'b1;
        step("R1", '0, '0, '0);
        step("R1", '0, '0, '0);
        // R9: privileged mode permits everything
        one0("R9", 4'd5, 32'h0);
        one0("R9", 4'd9, 32'h0);
        one0("R9", 4'd1, 32'hF000_0100);
        one0("R9", 4'd3, 32'h0);
        // R10: strobe low ignored
        step("R10", '0, {4'd0, 4'd4}, {32'd0, 32'h5555_0000});
        // R3: exit
        one0("R3", 4'd4, 32'h0000_1000);
        step("R10", '0, {4'd0, 4'd5}, '0);
        // R4 opcode faults, each followed by a return (R8 vector check)
        one0("R4", 4'd5, 32'h0);   one0("R3", 4'd4, 32'h100);
        one0("R4", 4'd6, 32'h0);   one0("R3", 4'd4, 32'h200);
        one0("R4", 4'd7, 32'h0);   one0("R3", 4'd4, 32'h300);
        one0("R4", 4'd8, 32'h0);   one0("R3", 4'd4, 32'h400);
        one0("R4", 4'd4, 32'h1000);one0("R3", 4'd4, 32'h500);
        // R5 IPR access
        one0("R5", 4'd9, 32'h0);   one0("R3", 4'd4, 32'h600);
        one0("R5", 4'd10, 32'h0);  one0("R3", 4'd4, 32'h700);
        one0("R5", 4'd2, 32'hE000_0010); one0("R3", 4'd4, 32'h800);
        one0("R5", 4'd2, 32'h1234_0000);
        // R6 region jump
        one0("R6", 4'd1, 32'hF000_0020); one0("R3", 4'd4, 32'h900);
        one0("R6", 4'd1, 32'h2000_0000);
        one0("R9", 4'd0, 32'hF000_0000);
        one0("R9", 4'd12, 32'hE000_0000);
        // R7 priority
        one0("R7", 4'd7, 32'hE000_0000); one0("R3", 4'd4, 32'hA00);
        one0("R7", 4'd4, 32'hF000_0000); one0("R3", 4'd4, 32'hB00);
        // R2 legal entry then R8 fault with other core busy (R11)
        one0("R2", 4'd3, 32'h1);
        step("R11", 2'b11, {4'd4, 4'd4}, {32'h3000_0000, 32'hC00});
        step("R11", 2'b11, {4'd0, 4'd5}, {32'h0, 32'h0});
        step("R11", 2'b11, {4'd3, 4'd2}, {32'h0, 32'h1000_0000});
        step("R8", 2'b00, '0, '0);
        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [N-1:0]    v;
            logic [N*4-1:0]  cc;
            logic [N*AW-1:0] aa;
            for (int c = 0; c < N; c++) begin
                logic [1:0] sel = 2'($urandom_range(0, 3));
                logic [3:0] hi  = (sel == 0) ? 4'hF : (sel == 1) ? 4'hE : (sel == 2) ? 4'h0 : 4'h3;
                v[c] = ($urandom_range(0, 7) != 0);
                cc[c*4 +: 4] = 4'($urandom_range(0, 15));
                aa[c*AW +: AW] = {hi, 28'($urandom)};
            end
            step("R11", v, cc, aa);
        end
        step("R11", '0, '0, '0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule